// File: doc/BRIEF.md
# Predictive Dead-Time Controller for a Synchronous Buck Half-Bridge

This block turns a single pulse-width command into two gate enables for a synchronous buck stage: one for the high-side main switch and one for the low-side synchronous rectifier. When the command goes high, the rectifier enable drops first. The main-switch enable then rises after a programmable dead interval. When the command goes low, the order is reversed. A strap input can invert the command before any other logic sees it, so the block works with controllers of either output polarity.

Each of the two dead intervals has its own delay register, counted in ticks of the fast clock. Each register is trimmed by a small loop that looks at a body-diode conduction flag. The flag is caught only while that interval's dead window is open. When a window closes, the register steps one tick down if conduction was seen and one tick up if it was not, always within that register's own limits. The delay used in any cycle is therefore decided by what happened in earlier cycles, not by the edge that is happening now.

Two more rules keep the bridge safe. The main switch may only turn on once a synchronized sense input reports the rectifier gate low. The two enables are never high together.

Top module: `pdt_ctrl`

## Requirements
- R1: With the polarity strap at 0, a command level of 1 settles to high-side enable on and rectifier enable off. A command level of 0 settles to rectifier enable on and high-side enable off.
- R2: With the polarity strap at 1, the command is inverted before all other logic. A pin level of 0 then acts as command 1, and a pin level of 1 acts as command 0.
- R3: Turn-off is never trimmed. The enable being switched off is still high one clock after the command pin changes and is low two clocks after it.
- R4: A switched-on enable rises exactly 2 + D clocks after the command pin changes. D is the current high-side delay (for a rising command) or the current rectifier delay (for a falling command).
- R5: When a dead window closes, its delay steps down by one if the synchronized conduction input was 1 in any cycle of that window. Otherwise it steps up by one.
- R6: The high-side delay stays within 4 to 12 ticks, and the rectifier delay stays within 5 to 9 ticks. A step that would leave the range holds the limit instead.
- R7: Each delay changes by at most one tick per switching cycle, and only when its own window closes.
- R8: Conduction seen outside a delay's own dead window has no effect on that delay. The window's flag is cleared each time the window opens.
- R9: The high-side enable does not rise while the synchronized rectifier-low sense is 0, even after its delay has expired. Once the sense returns to 1, the enable rises on the third clock. The two enables are never high together.
- R10: Reset loads both delays with their maximum values. Both enables stay off after reset until the command changes level for the first time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast tick clock |
| rst | input | 1 | Synchronous active-high reset |
| pwm_in | input | 1 | Pulse-width command pin |
| pol_inv | input | 1 | Polarity strap; 1 inverts the command |
| diode_sense | input | 1 | Asynchronous body-diode conduction comparator output |
| sr_low_sense | input | 1 | Asynchronous comparator, 1 when the rectifier gate is low |
| g1_on | output | 1 | High-side main switch gate enable |
| g2_on | output | 1 | Low-side rectifier gate enable |

## Verification
The bench builds the block with its default parameters: high-side limits of 4 and 12 ticks, rectifier limits of 5 and 9 ticks, and two synchronizer stages. These ranges are narrow, so a few runs of conduction or no conduction drive each loop into both clamps within about a dozen switching cycles. The two-stage synchronizer fixes the stall-release latency at three clocks, which is what lets the bench place an exact check on it. Each phase lasts thirty clocks. That is longer than the largest dead interval plus the pipeline, so a conduction pulse can be placed well outside a window and shown to be ignored.

// File: rtl/pdt_pkg.sv
package pdt_pkg;

    // Sequencing phases of the half-bridge
    typedef enum logic [2:0] {
        PH_IDLE,
        PH_HI_DEAD,
        PH_HI_ON,
        PH_LO_DEAD,
        PH_LO_ON
    } phase_e;

    // Window control handed from the sequencer to one trim loop
    typedef struct packed {
        logic open;    // window starts, flag is cleared
        logic active;  // window is running, flag may latch
        logic close;   // window completes, delay updates
    } win_t;

    // One trim step: down on conduction, up otherwise, clamped
    function automatic int unsigned pdt_next_delay(int unsigned cur, logic hit,
                                                   int unsigned lo, int unsigned hi);
        if (hit)
            return (cur > lo) ? cur - 1 : lo;
        else
            return (cur < hi) ? cur + 1 : hi;
    endfunction

endpackage

// File: rtl/pdt_sync.sv
module pdt_sync #(
    parameter int W      = 2,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] st [STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int k = 0; k < STAGES; k++) st[k] <= '0;
        end else begin
            st[0] <= d;
            for (int k = 1; k < STAGES; k++) st[k] <= st[k-1];
        end
    end

    assign q = st[STAGES-1];
endmodule

// File: rtl/pdt_trim.sv
module pdt_trim #(
    parameter int          DW   = 4,
    parameter int unsigned DMIN = 4,
    parameter int unsigned DMAX = 12
) (
    input  logic          clk,
    input  logic          rst,
    input  pdt_pkg::win_t win,
    input  logic          cond,
    output logic [DW-1:0] dly
);
    logic flag;
    logic hit;

    assign hit = flag | cond;

    always_ff @(posedge clk) begin
        if (rst) begin
            flag <= 1'b0;
            dly  <= DW'(DMAX);
        end else begin
            if (win.open)
                flag <= 1'b0;
            else if (win.active && cond)
                flag <= 1'b1;
            if (win.close)
                dly <= DW'(pdt_pkg::pdt_next_delay(32'(dly), hit, DMIN, DMAX));
        end
    end

    // R6
    dly_range_chk: assert property (@(posedge clk) disable iff (rst)
        (32'(dly) >= DMIN) && (32'(dly) <= DMAX));

    // R7
    dly_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !win.close |=> $stable(dly));

    // R7
    dly_step_chk: assert property (@(posedge clk) disable iff (rst)
        win.close |=> ((32'(dly) == 32'($past(dly)) + 1) ||
                       (32'(dly) + 1 == 32'($past(dly))) ||
                       (dly == $past(dly))));
endmodule

// File: rtl/pdt_seq.sv
module pdt_seq #(
    parameter int DW = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          cmd,
    input  logic          sr_ok,
    input  logic [DW-1:0] dly_hi,
    input  logic [DW-1:0] dly_lo,
    output logic          g1_q,
    output logic          g2_q,
    output pdt_pkg::win_t win_hi,
    output pdt_pkg::win_t win_lo
);
    import pdt_pkg::*;

    phase_e        phase;
    logic          cmd_q, cmd_d;
    logic [1:0]    warm;
    logic [DW-1:0] cnt;
    logic          armed, rise, fall;
    logic          hi_ready, lo_ready;

    assign armed    = (warm == 2'd2);
    assign rise     = armed &&  cmd_q && !cmd_d;
    assign fall     = armed && !cmd_q &&  cmd_d;
    assign hi_ready = (cnt >= dly_hi) && sr_ok;
    assign lo_ready = (cnt >= dly_lo);

    always_comb begin
        win_hi.open   = rise;
        win_hi.active = (phase == PH_HI_DEAD) && !rise && !fall;
        win_hi.close  = win_hi.active && hi_ready;
        win_lo.open   = fall;
        win_lo.active = (phase == PH_LO_DEAD) && !rise && !fall;
        win_lo.close  = win_lo.active && lo_ready;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= PH_IDLE;
            cmd_q <= 1'b0;
            cmd_d <= 1'b0;
            warm  <= 2'd0;
            cnt   <= '0;
            g1_q  <= 1'b0;
            g2_q  <= 1'b0;
        end else begin
            cmd_q <= cmd;
            cmd_d <= cmd_q;
            if (!armed) warm <= warm + 2'd1;
            if (rise) begin
                phase <= PH_HI_DEAD;
                g1_q  <= 1'b0;
                g2_q  <= 1'b0;
                cnt   <= DW'(1);
            end else if (fall) begin
                phase <= PH_LO_DEAD;
                g1_q  <= 1'b0;
                g2_q  <= 1'b0;
                cnt   <= DW'(1);
            end else begin
                unique case (phase)
                    PH_HI_DEAD: begin
                        if (hi_ready) begin
                            g1_q  <= 1'b1;
                            phase <= PH_HI_ON;
                        end else if (cnt != '1) begin
                            cnt <= cnt + DW'(1);
                        end
                    end
                    PH_LO_DEAD: begin
                        if (lo_ready) begin
                            g2_q  <= 1'b1;
                            phase <= PH_LO_ON;
                        end else if (cnt != '1) begin
                            cnt <= cnt + DW'(1);
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    // R9
    no_overlap_chk: assert property (@(posedge clk) disable iff (rst)
        !(g1_q && g2_q));

    // R9
    g1_gate_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(g1_q) |-> $past(sr_ok));

    // R3
    g1_off_chk: assert property (@(posedge clk) disable iff (rst)
        fall |=> !g1_q);

    // R3
    g2_off_chk: assert property (@(posedge clk) disable iff (rst)
        rise |=> !g2_q);

    // R10
    idle_off_chk: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_IDLE) |-> (!g1_q && !g2_q));
endmodule

// File: rtl/pdt_ctrl.sv
module pdt_ctrl #(
    parameter int unsigned G1_MIN      = 4,
    parameter int unsigned G1_MAX      = 12,
    parameter int unsigned G2_MIN      = 5,
    parameter int unsigned G2_MAX      = 9,
    parameter int          SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic pwm_in,
    input  logic pol_inv,
    input  logic diode_sense,
    input  logic sr_low_sense,
    output logic g1_on,
    output logic g2_on
);
    localparam int unsigned TOP_MAX = (G1_MAX > G2_MAX) ? G1_MAX : G2_MAX;
    localparam int          DW      = $clog2(TOP_MAX + 1);

    logic          cmd;
    logic [1:0]    sensed;
    logic [DW-1:0] dly_hi, dly_lo;
    pdt_pkg::win_t win_hi, win_lo;

    assign cmd = pwm_in ^ pol_inv;

    pdt_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   ({diode_sense, sr_low_sense}),
        .q   (sensed)
    );

    pdt_seq #(.DW(DW)) u_seq (
        .clk    (clk),
        .rst    (rst),
        .cmd    (cmd),
        .sr_ok  (sensed[0]),
        .dly_hi (dly_hi),
        .dly_lo (dly_lo),
        .g1_q   (g1_on),
        .g2_q   (g2_on),
        .win_hi (win_hi),
        .win_lo (win_lo)
    );

    pdt_trim #(.DW(DW), .DMIN(G1_MIN), .DMAX(G1_MAX)) u_trim_hi (
        .clk  (clk),
        .rst  (rst),
        .win  (win_hi),
        .cond (sensed[1]),
        .dly  (dly_hi)
    );

    pdt_trim #(.DW(DW), .DMIN(G2_MIN), .DMAX(G2_MAX)) u_trim_lo (
        .clk  (clk),
        .rst  (rst),
        .win  (win_lo),
        .cond (sensed[1]),
        .dly  (dly_lo)
    );
endmodule

// File: tb/tb_pdt_ctrl.sv
`timescale 1ns/1ps
module tb_pdt_ctrl;
    localparam int PH = 30;
    localparam int G1_LO = 4, G1_HI = 12, G2_LO = 5, G2_HI = 9;
    // {conduction in high-side window, conduction in rectifier window}
    localparam logic [1:0] VEC [14] = '{2'b00, 2'b11, 2'b11, 2'b11, 2'b11, 2'b11,
                                        2'b11, 2'b11, 2'b11, 2'b11, 2'b01, 2'b10,
                                        2'b01, 2'b00};

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic pwm_in = 1'b1, pol_inv = 1'b0, diode_sense = 1'b0, sr_low_sense = 1'b1;
    logic g1_on, g2_on;
    int checks = 0, failures = 0;
    int g1m, g2m, f;

    always #5 clk = ~clk;

    pdt_ctrl dut (
        .clk(clk), .rst(rst), .pwm_in(pwm_in), .pol_inv(pol_inv),
        .diode_sense(diode_sense), .sr_low_sense(sr_low_sense),
        .g1_on(g1_on), .g2_on(g2_on)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int step(input int cur, input bit hit, input int lo, input int hi);
        if (hit) return (cur > lo) ? cur - 1 : lo;
        return (cur < hi) ? cur + 1 : hi;
    endfunction

    task automatic do_reset();
        rst = 1'b1;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        g1m = G1_HI;
        g2m = G2_HI;
    endtask

    // Drive one command level, watch PH clocks, return first sample with the target on
    task automatic run_phase(input bit hi, input bit dio, input int pulse_from, output int first);
        bit oth_before, tgt, oth;
        first = 0;
        oth_before = hi ? g2_on : g1_on;
        pwm_in = hi ^ pol_inv;
        diode_sense = dio;
        for (int i = 1; i <= PH; i++) begin
            @(negedge clk);
            tgt = hi ? g1_on : g2_on;
            oth = hi ? g2_on : g1_on;
            if (g1_on && g2_on) check(0, "R9 both enables high", 1, 0);
            if (i == 1 && oth_before) check(oth == 1'b1, "R3 off enable one clock after", oth, 1);
            if (i == 2) check(oth == 1'b0, "R3 off enable two clocks after", oth, 0);
            if (first == 0 && tgt) first = i;
            if (pulse_from != 0) diode_sense = (i >= pulse_from && i < pulse_from + 3) ? 1'b1 : dio;
        end
        check(tgt == 1'b1 && oth == 1'b0, "R1 settled levels", {tgt, oth}, 2);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        bit any_on;
        do_reset();
        // R10: command held high through reset, no edge yet
        any_on = 1'b0;
        repeat (10) begin
            @(negedge clk);
            if (g1_on || g2_on) any_on = 1'b1;
        end
        check(!any_on, "R10 enables off before first edge", any_on, 0);

        run_phase(0, 0, 0, f);
        check(f == 2 + G2_HI, "R10 rectifier delay at maximum", f, 2 + G2_HI);
        g2m = step(g2m, 0, G2_LO, G2_HI);

        // Table walk: R4 R5 R6 R7
        foreach (VEC[v]) begin
            run_phase(1, VEC[v][1], 0, f);
            check(f == 2 + g1m, "R4 R5 R6 R7 high-side dead interval", f, 2 + g1m);
            g1m = step(g1m, VEC[v][1], G1_LO, G1_HI);
            run_phase(0, VEC[v][0], 0, f);
            check(f == 2 + g2m, "R4 R5 R6 R7 rectifier dead interval", f, 2 + g2m);
            g2m = step(g2m, VEC[v][0], G2_LO, G2_HI);
        end

        // R8: conduction pulse during rectifier on-time, outside every window
        run_phase(1, 0, 0, f);
        check(f == 2 + g1m, "R8 setup", f, 2 + g1m);
        g1m = step(g1m, 0, G1_LO, G1_HI);
        run_phase(0, 0, 24, f);
        check(f == 2 + g2m, "R8 pulse phase", f, 2 + g2m);
        g2m = step(g2m, 0, G2_LO, G2_HI);
        run_phase(1, 0, 0, f);
        check(f == 2 + g1m, "R8 out-of-window pulse ignored", f, 2 + g1m);
        g1m = step(g1m, 0, G1_LO, G1_HI);
        run_phase(0, 0, 0, f);
        check(f == 2 + g2m, "R8 rectifier delay unaffected", f, 2 + g2m);
        g2m = step(g2m, 0, G2_LO, G2_HI);

        // R9: high-side turn-on stalls on rectifier-low sense
        sr_low_sense = 1'b0;
        pwm_in = 1'b1;
        diode_sense = 1'b0;
        any_on = 1'b0;
        for (int i = 1; i <= 20; i++) begin
            @(negedge clk);
            if (g1_on) any_on = 1'b1;
        end
        check(!any_on, "R9 high-side held while sense low", any_on, 0);
        sr_low_sense = 1'b1;
        @(negedge clk);
        check(g1_on == 1'b0, "R9 release clock 1", g1_on, 0);
        @(negedge clk);
        check(g1_on == 1'b0, "R9 release clock 2", g1_on, 0);
        @(negedge clk);
        check(g1_on == 1'b1, "R9 release clock 3", g1_on, 1);
        g1m = step(g1m, 0, G1_LO, G1_HI);
        repeat (6) @(negedge clk);
        run_phase(0, 0, 0, f);
        check(f == 2 + g2m, "R9 following rectifier phase", f, 2 + g2m);
        g2m = step(g2m, 0, G2_LO, G2_HI);
        run_phase(1, 0, 0, f);
        check(f == 2 + g1m, "R9 stalled window still trimmed", f, 2 + g1m);

        // R2: inverted polarity strap
        pol_inv = 1'b1;
        pwm_in = 1'b1;
        do_reset();
        repeat (5) @(negedge clk);
        check(!g1_on && !g2_on, "R2 R10 off after reset with strap", {g1_on, g2_on}, 0);
        run_phase(1, 0, 0, f);
        check(f == 2 + G1_HI, "R2 low pin acts as high command", f, 2 + G1_HI);
        run_phase(0, 0, 0, f);
        check(f == 2 + G2_HI, "R2 high pin acts as low command", f, 2 + G2_HI);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule